// File: doc/BRIEF.md
# Strap-Configured GPIO Control Register

This block is one byte-wide control register on a simple host read/write bus. It owns one dual-role pin and four general-purpose I/O pins. Three configuration strap inputs are captured when reset is released, and they stay frozen until the next reset. The straps set three things: whether the dual-role pin is a suspend-request input or a general output, which level that output holds after reset, and whether the four I/O pins belong to software or are handed to internal alternate signals.

In output mode the control bit does not set an absolute level. It selects either the strapped reset level or its inverse. In input mode the pin is synchronized, and a separate power manager is told about suspend through `suspend_req`. Each I/O pin under software control is an output or an input, as its bit of `io_dir` selects. An output drives its register bit, and an input returns its synchronized pin level on a read. In alternate mode each pin is driven from `alt_out`, and register writes never reach the pin.

A small boot sequencer is in charge of strap capture. `ST_HELD` is forced while `rst_n` is low, and the straps are loaded on every clock in that state. After release it takes the transition HELD→FILL on the first clock edge, which is the capture edge. `ST_FILL` lasts `SYNC_STAGES` cycles while the synchronizers fill, then takes FILL→RUN. `ST_RUN` holds until the next reset.

Top module: `gpio_strap_ctrl`

## Requirements
- R1: The straps are captured on the first rising clock edge after `rst_n` rises. Later changes on `strap_i` change no output until the next reset.
- R2: When `strap_i[1]`=0, the dual-role pin is an input: `dp_oe`=0 and `dp_out`=0. Register bit 7 is still stored and reads back, but it has no effect on the pin.
- R3: When `strap_i[1]`=1, `dp_oe`=1. The strapped reset level is 1 if `strap_i[2]`=0 and 0 if `strap_i[2]`=1. With bit 7=0, `dp_out` equals that level. With bit 7=1, `dp_out` is its inverse.
- R4: The register answers only at address 0x21. Bit 7 is the control bit, bit n (n=0..3) belongs to `io_*[n]`, and bits 6:4 read 0. Reads at any other address return 0x00, and writes there change nothing.
- R5: Reset clears bit 7 and bits 3:0 to 0, so a read after reset returns 0x00.
- R6: In software mode (`strap_i[0]`=1), a pin with `io_dir[n]`=1 has `io_oe[n]`=1 and `io_out[n]` equal to the written bit, and a read returns the written bit.
- R7: In software mode, a pin with `io_dir[n]`=0 has `io_oe[n]`=0 and `io_out[n]`=0. A read returns `io_in[n]` as it was two clock edges earlier.
- R8: In alternate mode (`strap_i[0]`=0), `io_oe`=4'hF and `io_out` follows `alt_out`, whatever `io_dir` and the writes are. A read of bits 3:0 returns the stored bits.
- R9: In input mode, `suspend_req` goes to 1 two edges after `dp_in` falls and back to 0 two edges after it rises. It is always 0 in output mode.
- R10: `suspend_req` stays 0 until the sequencer reaches `ST_RUN`, which happens on the third clock edge after reset release with `SYNC_STAGES`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are captured after it rises |
| strap_i | input | 3 | [0] I/O pins to software, [1] dual pin is output, [2] output reset level low |
| bus_addr | input | 8 | Host byte address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the current address (combinational) |
| io_dir | input | 4 | Per-pin direction in software mode, 1 = output |
| io_in | input | 4 | Pin levels from the pads |
| alt_out | input | 4 | Alternate-function signals (retrace and DAC register select) |
| io_out | output | 4 | Pin output levels |
| io_oe | output | 4 | Pin output enables |
| dp_in | input | 1 | Dual-role pin level, active-low suspend request |
| dp_out | output | 1 | Dual-role pin output level |
| dp_oe | output | 1 | Dual-role pin output enable |
| suspend_req | output | 1 | Suspend request to the power manager |

## Verification
Every strap combination that matters is used: output with either reset level, input, and alternate mode. This separates a design that drives the dual-role pin to an absolute level from one that drives it relative to the strapped level. In the mixed-direction test, the pin levels are chosen opposite to the written bits, so a readback that returns the wrong source gives a different byte. The suspend input is sampled edge by edge across the fill phase and across a release, which exposes a missing synchronizer stage or a missing run gate. Strap changes after release, and writes at a neighbouring address, show whether state is captured only where it should be.

// File: rtl/gpio_strap_pkg.sv
package gpio_strap_pkg;

    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_t;

    typedef struct packed {
        logic gpo_low_rst;   // output reset level is 0
        logic dual_is_out;   // dual-role pin acts as output
        logic io_soft;       // I/O pins under software control
    } strap_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/gpio_strap_seq.sv
module gpio_strap_seq
    import gpio_strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    output strap_t     strap_q,
    output logic       run_o,
    output logic       capture_o
);

    localparam int                CNT_W     = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0]  FILL_LAST = CNT_W'(SYNC_STAGES - 1);

    boot_state_t      state_q;
    boot_state_t      state_d;
    logic [CNT_W-1:0] fill_cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_HELD;
            fill_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) fill_cnt_q <= fill_cnt_q + 1'b1;
            else                    fill_cnt_q <= '0;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: state_d = ST_FILL;
            ST_FILL: state_d = (fill_cnt_q == FILL_LAST) ? ST_RUN : ST_FILL;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HELD;
        endcase
    end

    // Outputs
    always_comb begin
        capture_o = (state_q == ST_HELD);
        run_o     = (state_q == ST_RUN);
    end

    // Strap latch: tracks the straps while held, frozen afterwards
    always_ff @(posedge clk) begin
        if (capture_o) strap_q <= strap_t'(strap_i);
    end

endmodule

// File: rtl/gpio_io_mux.sv
module gpio_io_mux #(
    parameter int NUM_IO = 4
) (
    input  logic              io_soft,
    input  logic [NUM_IO-1:0] io_dir,
    input  logic [NUM_IO-1:0] latch,
    input  logic [NUM_IO-1:0] alt_out,
    input  logic [NUM_IO-1:0] pin_sync,
    output logic [NUM_IO-1:0] io_out,
    output logic [NUM_IO-1:0] io_oe,
    output logic [NUM_IO-1:0] rd_bits
);

    for (genvar i = 0; i < NUM_IO; i++) begin : g_pin
        assign io_out[i]  = !io_soft ? alt_out[i] : (io_dir[i] & latch[i]);
        assign io_oe[i]   = !io_soft | io_dir[i];
        assign rd_bits[i] = (!io_soft | io_dir[i]) ? latch[i] : pin_sync[i];
    end

endmodule

// File: rtl/gpio_strap_ctrl.sv
module gpio_strap_ctrl
    import gpio_strap_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter int                NUM_IO      = 4,
    parameter int                CTL_BIT     = 7,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IO-1:0] io_dir,
    input  logic [NUM_IO-1:0] io_in,
    input  logic [NUM_IO-1:0] alt_out,
    output logic [NUM_IO-1:0] io_out,
    output logic [NUM_IO-1:0] io_oe,
    input  logic              dp_in,
    output logic              dp_out,
    output logic              dp_oe,
    output logic              suspend_req
);

    strap_t            strap_q;
    logic              in_run;
    logic              capture;
    logic              hit;
    logic              ctl_q;
    logic [NUM_IO-1:0] latch_q;
    logic [NUM_IO-1:0] io_sync;
    logic [NUM_IO-1:0] rd_bits;
    logic              dp_sync;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[CTL_BIT-1:NUM_IO];

    gpio_strap_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .strap_q   (strap_q),
        .run_o     (in_run),
        .capture_o (capture)
    );

    gpio_sync #(.WIDTH(NUM_IO), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_io_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (io_in),
        .q_o   (io_sync)
    );

    gpio_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dp_in),
        .q_o   (dp_sync)
    );

    assign hit = (bus_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= 1'b0;
            latch_q <= '0;
        end else if (bus_wr && hit) begin
            ctl_q   <= bus_wdata[CTL_BIT];
            latch_q <= bus_wdata[NUM_IO-1:0];
        end
    end

    gpio_io_mux #(.NUM_IO(NUM_IO)) u_mux (
        .io_soft  (strap_q.io_soft),
        .io_dir   (io_dir),
        .latch    (latch_q),
        .alt_out  (alt_out),
        .pin_sync (io_sync),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .rd_bits  (rd_bits)
    );

    always_comb begin
        if (strap_q.dual_is_out) begin
            dp_oe  = 1'b1;
            dp_out = (~strap_q.gpo_low_rst) ^ ctl_q;
        end else begin
            dp_oe  = 1'b0;
            dp_out = 1'b0;
        end
        suspend_req = !strap_q.dual_is_out && in_run && !dp_sync;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[CTL_BIT]    = ctl_q;
            bus_rdata[NUM_IO-1:0] = rd_bits;
        end
    end

endmodule

// File: rtl/gpio_strap_ctrl_chk.sv
module gpio_strap_ctrl_chk
    import gpio_strap_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                NUM_IO   = 4,
    parameter int                CTL_BIT  = 7,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h21
) (
    input logic              clk,
    input logic              rst_n,
    input strap_t            strap_q,
    input logic              in_run,
    input logic              capture,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_IO-1:0] io_dir,
    input logic [NUM_IO-1:0] alt_out,
    input logic [NUM_IO-1:0] io_out,
    input logic [NUM_IO-1:0] io_oe,
    input logic              dp_out,
    input logic              dp_oe,
    input logic              suspend_req
);

    // R1
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && $past(!capture)) |-> $stable(strap_q));

    // R2
    dp_input_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !strap_q.dual_is_out) |-> (!dp_oe && !dp_out));

    // R3
    gpo_relative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR && !capture && strap_q.dual_is_out)
        |=> (dp_out == ($past(bus_wdata[CTL_BIT]) ^ !strap_q.gpo_low_rst)));

    // R6
    io_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR && !capture && strap_q.io_soft)
        |=> ((io_out & io_dir) == ($past(bus_wdata[NUM_IO-1:0]) & io_dir)));

    // R8
    alt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !strap_q.io_soft) |-> (io_oe == '1 && io_out == alt_out));

    // R9
    susp_out_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q.dual_is_out |-> !suspend_req);

    // R10
    susp_run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |-> !suspend_req);

    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_run) |-> in_run);

endmodule

bind gpio_strap_ctrl gpio_strap_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_IO   (NUM_IO),
    .CTL_BIT  (CTL_BIT),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_q     (strap_q),
    .in_run      (in_run),
    .capture     (capture),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .io_dir      (io_dir),
    .alt_out     (alt_out),
    .io_out      (io_out),
    .io_oe       (io_oe),
    .dp_out      (dp_out),
    .dp_oe       (dp_oe),
    .suspend_req (suspend_req)
);

// File: tb/sim_gpio_strap_ctrl.sv
module sim_gpio_strap_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [7:0] REG = 8'h21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_i = 3'b011;
    logic [7:0] bus_addr = REG;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] io_dir = 4'h0;
    logic [3:0] io_in = 4'h0;
    logic [3:0] alt_out = 4'h0;
    logic [3:0] io_out;
    logic [3:0] io_oe;
    logic       dp_in = 1'b1;
    logic       dp_out;
    logic       dp_oe;
    logic       suspend_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_strap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .io_dir(io_dir), .io_in(io_in),
        .alt_out(alt_out), .io_out(io_out), .io_oe(io_oe),
        .dp_in(dp_in), .dp_out(dp_out), .dp_oe(dp_oe),
        .suspend_req(suspend_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst_n   = 1'b0;
        strap_i = s;
        bus_wr  = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = REG;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = REG;
    endtask

    task automatic t_reset_state;
        logic [7:0] v;
        io_dir = 4'hF;
        do_reset(3'b011);
        bus_read(REG, v);
        check("R5 readback after reset", v, 8'h00);
        check("R3 dp_oe output mode", dp_oe, 1);
        check("R3 reset level high", dp_out, 1);
        check("R5 io_out cleared", io_out, 4'h0);
    endtask

    task automatic t_gpo;
        logic [7:0] v;
        dp_in = 1'b0;
        bus_write(REG, 8'h80);
        check("R3 inverted level", dp_out, 0);
        bus_read(REG, v);
        check("R4 bit7 readback", v, 8'h80);
        tick(3);
        check("R9 no suspend in output mode", suspend_req, 0);
        bus_write(REG, 8'h00);
        check("R3 back to reset level", dp_out, 1);
        dp_in = 1'b1;
        do_reset(3'b111);
        check("R3 reset level low", dp_out, 0);
        bus_write(REG, 8'h80);
        check("R3 inverted low level", dp_out, 1);
    endtask

    task automatic t_strap_hold;
        do_reset(3'b111);
        strap_i = 3'b000;
        tick(4);
        check("R1 dp_oe frozen", dp_oe, 1);
        check("R1 dp_out frozen", dp_out, 0);
        io_dir = 4'hF;
        bus_write(REG, 8'h05);
        check("R1 io still software", io_out, 4'h5);
    endtask

    task automatic t_suspend;
        logic [7:0] v;
        @(negedge clk);
        rst_n   = 1'b0;
        strap_i = 3'b001;
        dp_in   = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R10 masked first fill cycle", suspend_req, 0);
        tick(1);
        check("R10 masked while filling", suspend_req, 0);
        tick(1);
        check("R10 asserted in run", suspend_req, 1);
        dp_in = 1'b1;
        tick(1);
        check("R9 one edge after release", suspend_req, 1);
        tick(1);
        check("R9 two edges after release", suspend_req, 0);
        check("R2 dp_oe input mode", dp_oe, 0);
        bus_write(REG, 8'h80);
        bus_read(REG, v);
        check("R2 bit7 stored", v[7], 1);
        check("R2 dp_out unaffected", dp_out, 0);
        check("R2 dp_oe unaffected", dp_oe, 0);
    endtask

    task automatic t_sw_out;
        logic [7:0] v;
        io_in  = 4'h5;
        io_dir = 4'hF;
        do_reset(3'b011);
        bus_write(REG, 8'h0A);
        check("R6 io_out", io_out, 4'hA);
        check("R6 io_oe", io_oe, 4'hF);
        bus_read(REG, v);
        check("R6 readback latch", v, 8'h0A);
        io_dir = 4'h5;
        #1;
        check("R7 mixed io_out", io_out, 4'h0);
        check("R7 mixed io_oe", io_oe, 4'h5);
        bus_read(REG, v);
        check("R7 mixed readback", v, 8'h05 & 8'h0A | 8'h00);
    endtask

    task automatic t_sw_in;
        logic [7:0] v;
        io_dir = 4'h0;
        bus_write(REG, 8'h00);
        bus_read(REG, v);
        check("R7 input readback steady", v, 8'h05);
        io_in = 4'hA;
        tick(1);
        bus_read(REG, v);
        check("R7 one edge old value", v, 8'h05);
        tick(1);
        bus_read(REG, v);
        check("R7 two edges new value", v, 8'h0A);
        check("R7 input oe low", io_oe, 4'h0);
    endtask

    task automatic t_alt;
        logic [7:0] v;
        io_dir  = 4'h0;
        alt_out = 4'h9;
        do_reset(3'b010);
        check("R8 alt drive", io_out, 4'h9);
        check("R8 alt oe", io_oe, 4'hF);
        bus_write(REG, 8'h06);
        check("R8 write ignored on pins", io_out, 4'h9);
        bus_read(REG, v);
        check("R8 stored bits readback", v, 8'h06);
        alt_out = 4'h3;
        io_dir  = 4'hF;
        #1;
        check("R8 follows alt_out", io_out, 4'h3);
        check("R8 oe ignores dir", io_oe, 4'hF);
    endtask

    task automatic t_addr;
        logic [7:0] v;
        io_dir = 4'hF;
        do_reset(3'b011);
        bus_write(8'h20, 8'hFF);
        bus_read(REG, v);
        check("R4 other address write ignored", v, 8'h00);
        check("R4 pins unchanged", io_out, 4'h0);
        bus_write(REG, 8'hFF);
        bus_read(REG, v);
        check("R4 unused bits zero", v, 8'h8F);
        bus_read(8'h20, v);
        check("R4 other address reads zero", v, 8'h00);
        check("R4 bit n to pin n", io_out, 4'hF);
    endtask

    initial begin
        tick(2);
        t_reset_state();
        t_gpo();
        t_strap_hold();
        t_suspend();
        t_sw_out();
        t_sw_in();
        t_alt();
        t_addr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule